// File: doc/BRIEF.md
# Fractional-Increment PTP Time-of-Day Counter

This block keeps a running time of day for precision time stamping. It holds a 48-bit seconds count and a 30-bit nanoseconds count. On every clock edge the nanoseconds advance by a programmable whole-nanosecond step. A 24-bit sub-nanosecond fraction is added into an accumulator on the same edge, and each carry out of that accumulator adds one more nanosecond. Software trims the clock rate by changing the whole and fractional parts of the step. The block does not compute those values.

A plain register port writes and reads the time and the step. It has one write strobe, a 3-bit register select, 32-bit write data and combinational read data. The time setting follows fixed ordering rules:
- The upper seconds word waits in a holding register until the lower seconds word is written.
- The fraction waits until the whole-nanosecond step is written, and then both take effect together.
- A signed adjust write shifts the running time once.

The current seconds and nanoseconds are always driven out for timestamp capture. These are control and status pins only, so there is no valid/ready handshake. Every write is taken in the cycle in which it is presented.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the seconds, the nanoseconds, both step fields, the pending fraction, the pending upper seconds and the fraction accumulator are all zero.
- R2: Each cycle the nanoseconds advance by the whole step, plus one when adding the committed fraction into the 24-bit accumulator carries out of bit 23. The accumulator keeps running in every cycle, including cycles with a write.
- R3: The nanoseconds stay below 1,000,000,000. Passing that value wraps them and carries one into the 48-bit seconds count, which wraps modulo 2^48.
- R4: A write to select 1 stores wdata[15:0] as the pending upper seconds word and leaves the running time unchanged. A write to select 0 loads the seconds with {pending upper word, wdata}. In that cycle the nanoseconds still advance, and any carry into the seconds is dropped.
- R5: A write to select 2 with wdata below 1,000,000,000 loads the nanoseconds from wdata and leaves the seconds unchanged in that cycle. A larger value is ignored, and the counter then advances normally.
- R6: A write to select 3 stores the pending fraction as {wdata[15:0], wdata[31:24]}. That is, register bits 15:0 become fraction bits 23:8, and bits 31:24 become fraction bits 7:0. Counting keeps using the previously committed fraction.
- R7: A write to select 4 commits wdata[7:0] as the whole step and the pending fraction as the committed fraction in the same edge. Both are used from the next cycle on.
- R8: A write to select 5 applies a one-time offset in that cycle, on top of the normal step. wdata[31]=1 subtracts and wdata[31]=0 adds. The magnitude is wdata[30:0] and is applied only when it is below 1,000,000,000; otherwise the write is ignored. A borrow out of, or carry into, the nanoseconds changes the seconds by -1, +1 or +2.
- R9: While the whole step and the committed fraction are both zero and no write occurs, the time does not change.
- R10: Read data follows the select with no clock delay:
  - select 0 gives seconds[31:0];
  - select 1 gives {16'b0, seconds[47:32]} of the running time;
  - select 2 gives the nanoseconds;
  - select 3 gives the committed fraction in the R6 layout, with bits 23:16 zero;
  - select 4 gives {24'b0, whole step};
  - other selects give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; the time advances on each rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for reg_sel |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |

## Verification
The hardest cases to reach from the ports are those where two carry sources meet in one edge. One is a fraction carry that pushes the nanoseconds across the one-second boundary. Another is a maximal add adjust combined with a near-full nanoseconds count, which must move the seconds by two. A third is a seconds load that must discard a carry arising in the same cycle. Directed sequences reach them by loading the nanoseconds close to 999,999,999 and committing a step of 255 with a fraction that carries on alternate cycles. The sequences then apply adjust or seconds writes exactly at the rollover. Seeded random writes of all kinds, including out-of-range values, follow, and every cycle is compared against a bench model of the time.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int NS_W     = 30;
  localparam int SEC_W    = 48;
  localparam int SEC_LO_W = 32;
  localparam int SEC_HI_W = SEC_W - SEC_LO_W;
  localparam int STEP_W   = 8;
  localparam int FRAC_W   = 24;
  localparam int SEL_W    = 3;
  localparam int DATA_W   = 32;
  localparam int FRAC_HI_W = 16;
  localparam int FRAC_LO_W = FRAC_W - FRAC_HI_W;
  localparam logic [DATA_W-1:0] NS_PER_SEC = 32'd1000000000;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC_LO = 3'd0,
    SEL_SEC_HI = 3'd1,
    SEL_NSEC   = 3'd2,
    SEL_FRAC   = 3'd3,
    SEL_STEP   = 3'd4,
    SEL_ADJ    = 3'd5
  } reg_sel_e;

  function automatic logic [FRAC_W-1:0] frac_from_word(input logic [DATA_W-1:0] w);
    return {w[FRAC_HI_W-1:0], w[DATA_W-1 -: FRAC_LO_W]};
  endfunction

  function automatic logic [DATA_W-1:0] word_from_frac(input logic [FRAC_W-1:0] f);
    logic [DATA_W-1:0] w;
    w = '0;
    w[FRAC_HI_W-1:0] = f[FRAC_W-1:FRAC_LO_W];
    w[DATA_W-1 -: FRAC_LO_W] = f[FRAC_LO_W-1:0];
    return w;
  endfunction
endpackage

// File: rtl/ptp_step_regs.sv
module ptp_step_regs
  import ptp_tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frac_wr,
  input  logic              step_wr,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic [STEP_W-1:0] step_in,
  output logic [STEP_W-1:0] step_ns,
  output logic [FRAC_W-1:0] step_frac
);
  logic [FRAC_W-1:0] frac_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_pend <= '0;
      step_ns   <= '0;
      step_frac <= '0;
    end else begin
      if (frac_wr) frac_pend <= frac_in;
      if (step_wr) begin
        step_ns   <= step_in;
        step_frac <= frac_pend;
      end
    end
  end

  // R6/R7: the committed step changes only on a step write
  p_commit_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_wr |=> $stable(step_frac) && $stable(step_ns));
endmodule

// File: rtl/ptp_frac_acc.sv
module ptp_frac_acc
  import ptp_tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step_ns,
  input  logic [FRAC_W-1:0] step_frac,
  output logic [STEP_W:0]   step
);
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   acc_sum;

  always_comb begin
    acc_sum = {1'b0, acc} + {1'b0, step_frac};
    step    = {1'b0, step_ns} + {{STEP_W{1'b0}}, acc_sum[FRAC_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_sum[FRAC_W-1:0];
  end

  // R2: without a fraction the step is exactly the whole increment
  p_no_frac_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_frac == '0) |-> (step == {1'b0, step_ns}));
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
  import ptp_tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W:0]   step,
  input  logic              ld_ns,
  input  logic [NS_W-1:0]   ns_val,
  input  logic              ld_sec,
  input  logic [SEC_W-1:0]  sec_val,
  input  logic              adj_en,
  input  logic              adj_sub,
  input  logic [NS_W-1:0]   adj_mag,
  output logic [SEC_W-1:0]  sec,
  output logic [NS_W-1:0]   ns
);
  localparam int SUM_W = NS_W + 4;
  localparam logic signed [SUM_W-1:0] ONE_SEC = SUM_W'(NS_PER_SEC);
  localparam logic signed [SUM_W-1:0] TWO_SEC = ONE_SEC + ONE_SEC;

  logic signed [SUM_W-1:0] base, sum, wrapped;
  logic signed [2:0]       dsec;

  always_comb begin
    base = $signed({4'b0, ns}) + $signed({{(SUM_W-STEP_W-1){1'b0}}, step});
    if (!adj_en)      sum = base;
    else if (adj_sub) sum = base - $signed({4'b0, adj_mag});
    else              sum = base + $signed({4'b0, adj_mag});
    if (sum < 0) begin
      wrapped = sum + ONE_SEC;
      dsec    = -3'sd1;
    end else if (sum >= TWO_SEC) begin
      wrapped = sum - TWO_SEC;
      dsec    = 3'sd2;
    end else if (sum >= ONE_SEC) begin
      wrapped = sum - ONE_SEC;
      dsec    = 3'sd1;
    end else begin
      wrapped = sum;
      dsec    = 3'sd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns  <= '0;
      sec <= '0;
    end else begin
      ns <= ld_ns ? ns_val : wrapped[NS_W-1:0];
      if (ld_sec)      sec <= sec_val;
      else if (!ld_ns) sec <= sec + {{(SEC_W-3){dsec[2]}}, dsec};
    end
  end

  // R3: nanoseconds never reach one second
  p_ns_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    {2'b0, ns} < NS_PER_SEC);
  // R4: without a load or adjust, seconds move by at most one
  p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_sec && !adj_en) |=> ((sec - $past(sec)) <= SEC_W'(1)));
  // R5: a nanosecond load leaves the seconds untouched
  p_ns_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ns && !ld_sec) |=> $stable(sec));
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns
);
  logic [SEC_HI_W-1:0] sec_hi_pend;
  logic [STEP_W-1:0]   step_ns;
  logic [FRAC_W-1:0]   step_frac;
  logic [STEP_W:0]     step;
  logic wr_hi, wr_lo, wr_ns, wr_frac, wr_step, wr_adj;

  always_comb begin
    wr_hi   = wr_en && (reg_sel == SEL_SEC_HI);
    wr_lo   = wr_en && (reg_sel == SEL_SEC_LO);
    wr_ns   = wr_en && (reg_sel == SEL_NSEC) && (wdata < NS_PER_SEC);
    wr_frac = wr_en && (reg_sel == SEL_FRAC);
    wr_step = wr_en && (reg_sel == SEL_STEP);
    wr_adj  = wr_en && (reg_sel == SEL_ADJ) && ({1'b0, wdata[DATA_W-2:0]} < NS_PER_SEC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sec_hi_pend <= '0;
    else if (wr_hi) sec_hi_pend <= wdata[SEC_HI_W-1:0];
  end

  ptp_step_regs u_step (
    .clk(clk), .rst_n(rst_n), .frac_wr(wr_frac), .step_wr(wr_step),
    .frac_in(frac_from_word(wdata)), .step_in(wdata[STEP_W-1:0]),
    .step_ns(step_ns), .step_frac(step_frac));

  ptp_frac_acc u_acc (
    .clk(clk), .rst_n(rst_n), .step_ns(step_ns), .step_frac(step_frac),
    .step(step));

  ptp_time_core u_core (
    .clk(clk), .rst_n(rst_n), .step(step),
    .ld_ns(wr_ns), .ns_val(wdata[NS_W-1:0]),
    .ld_sec(wr_lo), .sec_val({sec_hi_pend, wdata}),
    .adj_en(wr_adj), .adj_sub(wdata[DATA_W-1]), .adj_mag(wdata[NS_W-1:0]),
    .sec(tod_sec), .ns(tod_ns));

  always_comb begin
    case (reg_sel)
      SEL_SEC_LO: rdata = tod_sec[SEC_LO_W-1:0];
      SEL_SEC_HI: rdata = {{(DATA_W-SEC_HI_W){1'b0}}, tod_sec[SEC_W-1:SEC_LO_W]};
      SEL_NSEC:   rdata = {{(DATA_W-NS_W){1'b0}}, tod_ns};
      SEL_FRAC:   rdata = word_from_frac(step_frac);
      SEL_STEP:   rdata = {{(DATA_W-STEP_W){1'b0}}, step_ns};
      default:    rdata = '0;
    endcase
  end

  // R9: zero increment and no write keeps time frozen
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ns == '0 && step_frac == '0 && !wr_en) |=> ($stable(tod_ns) && $stable(tod_sec)));
  // R4: an upper-seconds write alone never disturbs the seconds count beyond a carry
  p_hi_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> ((tod_sec - $past(tod_sec)) <= SEC_W'(1)));
endmodule

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;

  int total = 0;
  int bad = 0;

  logic [47:0] m_sec;
  longint      m_ns;
  logic [23:0] m_acc, m_frac, m_pend;
  logic [7:0]  m_step;
  logic [15:0] m_hi;
  localparam longint SEC1 = 64'd1000000000;

  always #5 clk = ~clk;

  ptp_tod_counter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rdata), .tod_sec(tod_sec), .tod_ns(tod_ns));

  function automatic logic [31:0] exp_read(input logic [2:0] s);
    case (s)
      3'd0: return m_sec[31:0];
      3'd1: return {16'h0, m_sec[47:32]};
      3'd2: return m_ns[31:0];
      3'd3: return {m_frac[7:0], 8'h00, m_frac[23:8]};
      3'd4: return {24'h0, m_step};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sec = '0; m_ns = 0; m_acc = '0; m_frac = '0; m_pend = '0; m_step = '0; m_hi = '0;
  endtask

  // one clock: drive at negedge, advance model, check after the edge
  task automatic cyc(input bit wr, input logic [2:0] s, input logic [31:0] d, input string tag);
    longint sum, dsec;
    logic [24:0] a;
    @(negedge clk);
    wr_en = wr; reg_sel = s; wdata = d;
    a = {1'b0, m_acc} + {1'b0, m_frac};
    sum = m_ns + m_step + a[24];
    if (wr && s == 3'd5 && d[30:0] < 31'd1000000000)
      sum = d[31] ? sum - longint'(d[30:0]) : sum + longint'(d[30:0]);
    dsec = 0;
    while (sum < 0) begin sum += SEC1; dsec--; end
    while (sum >= SEC1) begin sum -= SEC1; dsec++; end
    m_acc = a[23:0];
    if (wr && s == 3'd2 && d < 32'd1000000000) m_ns = longint'(d);
    else begin
      m_ns = sum;
      if (!(wr && s == 3'd0)) m_sec = m_sec + 48'(dsec);
    end
    if (wr && s == 3'd0) m_sec = {m_hi, d};
    if (wr && s == 3'd1) m_hi = d[15:0];
    if (wr && s == 3'd3) m_pend = {d[15:0], d[31:24]};
    if (wr && s == 3'd4) begin m_step = d[7:0]; m_frac = m_pend; end
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    chk(tod_sec == m_sec, {tag, " seconds"}, 64'(tod_sec), 64'(m_sec));
    chk(longint'(tod_ns) == m_ns, {tag, " nanoseconds"}, 64'(tod_ns), 64'(m_ns));
    if (!wr) chk(rdata == exp_read(s), "R10 readback", 64'(rdata), 64'(exp_read(s)));
  endtask

  task automatic idle(input int n, input logic [2:0] s, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, s, 32'h0, tag);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        void'($urandom(32'h1588));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(tod_sec == 48'd0 && tod_ns == 30'd0, "R1 reset time", {tod_sec[31:0], 2'b0, tod_ns}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        idle(4, 3'd4, "R1 R9 frozen after reset");
        // pending upper seconds, ns clear, lower seconds load
        cyc(1'b1, 3'd1, 32'h0000_0012, "R4 upper pending");
        idle(2, 3'd1, "R4 upper not applied");
        cyc(1'b1, 3'd2, 32'd0, "R5 ns clear");
        cyc(1'b1, 3'd0, 32'h89AB_CDEF, "R4 lower loads seconds");
        idle(2, 3'd0, "R4 seconds held");
        // fraction pending, then commit
        cyc(1'b1, 3'd3, 32'h3400_5678, "R6 fraction pending");
        idle(3, 3'd3, "R6 still frozen");
        cyc(1'b1, 3'd4, 32'd8, "R7 commit step");
        idle(20, 3'd3, "R2 step with fraction");
        // rollover
        cyc(1'b1, 3'd2, 32'd999_999_990, "R5 ns load");
        idle(4, 3'd2, "R3 rollover carry");
        cyc(1'b1, 3'd2, 32'd1_000_000_005, "R5 out-of-range ns ignored");
        // seconds load drops same-cycle carry
        cyc(1'b1, 3'd2, 32'd999_999_999, "R5 ns near top");
        cyc(1'b1, 3'd0, 32'h0000_0100, "R4 carry dropped on load");
        // step 255 with half fraction and maximal add adjust
        cyc(1'b1, 3'd3, 32'h0000_8000, "R6 half fraction");
        cyc(1'b1, 3'd4, 32'd255, "R7 commit 255");
        cyc(1'b1, 3'd2, 32'd999_999_999, "R5 ns top");
        cyc(1'b1, 3'd5, 32'd999_999_999, "R8 add adjust double carry");
        cyc(1'b1, 3'd5, 32'h8000_0000 | 32'd999_999_999, "R8 subtract adjust borrow");
        cyc(1'b1, 3'd5, 32'h4000_0000, "R8 oversized adjust ignored");
        // borrow below zero seconds
        cyc(1'b1, 3'd1, 32'h0, "R4 upper zero");
        cyc(1'b1, 3'd0, 32'h0, "R4 seconds zero");
        cyc(1'b1, 3'd5, 32'h8000_0000 | 32'd500_000_000, "R8 borrow wraps seconds");
        // fraction-only increment
        cyc(1'b1, 3'd4, 32'd0, "R7 commit fraction only");
        idle(8, 3'd2, "R2 fraction-only carry");
        // zero increment freezes
        cyc(1'b1, 3'd3, 32'h0, "R6 zero fraction");
        cyc(1'b1, 3'd4, 32'd0, "R7 commit zero");
        idle(6, 3'd2, "R9 frozen");
        idle(1, 3'd6, "R10 unused select");
        // random mix
        for (int i = 0; i < 3000; i++) begin
          logic [2:0] s;
          logic [31:0] d;
          bit w;
          s = 3'($urandom_range(0, 7));
          w = ($urandom_range(0, 3) == 0);
          d = $urandom();
          if (s == 3'd2 && $urandom_range(0, 7) != 0) d = $urandom_range(0, 999_999_999);
          if (s == 3'd5 && $urandom_range(0, 7) != 0)
            d = {d[31], 1'b0, 30'($urandom_range(0, 999_999_999))};
          if (s == 3'd2 && $urandom_range(0, 3) == 0) d = 32'd999_999_000 + $urandom_range(0, 999);
          cyc(w, s, d, "R2 R3 R4 R5 R6 R7 R8 random");
        end
        done = 1;
      end
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog act=hung exp=done");
        end
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule